// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status Unit

This block collects the interrupt causes of a small Ethernet MAC into one 8-bit status word and drives a single interrupt request line. The status word mixes three kinds of bits. Sticky bits capture an event and hold it until software acknowledges them. Live bits are the inverse of the empty flags of the receive and transmit-completion packet-number queues. One bit is owned by the transmit page allocator, which sets and clears it.

Software reaches the unit over a simple synchronous register bus. Address 0 reads the status word. A write to address 0 is a write-one-to-clear acknowledge that lasts one cycle. Address 1 holds an 8-bit mask. The interrupt line is high whenever a status bit and its mask bit are both 1.

Acknowledging the transmit-done position does not change a stored bit. Instead it pops the serviced packet number from the head of the transmit-completion queue.

Top module: `eth_irq_status`

## Requirements
- R1: Status bit 4 (receive overrun) is set in the cycle after any of the three receive abort pulses is high: allocation failure, frame over 2048 bytes, or receive discard.
- R2: Status bit 4 is cleared only by a write to address 0 with data bit 4 set. Writes with bit 4 clear leave it set. When an abort pulse and the clearing write fall in the same cycle, the bit stays set.
- R3: Status bit 3 (allocation done) is set in the cycle after `alloc_ok`. The output `alloc_failed` is always the inverse of status bit 3.
- R4: Status bit 3 is cleared in the cycle after `alloc_start` or `alloc_fail`, unless `alloc_ok` is high in the same cycle. An acknowledge write to bit 3 has no effect on it.
- R5: Status bit 2 (transmit empty) is set in the cycle after any cycle in which `tx_fifo_empty` is high. It is cleared by an acknowledge write with data bit 2 set. The setting condition wins over the acknowledge, so while the FIFO stays empty the bit reads 1 again right after the acknowledge.
- R6: Status bit 1 (transmit done) equals the inverse of `txq_empty`. An acknowledge write with data bit 1 set raises `txq_pop` in that same cycle when `txq_empty` is 0. When `txq_empty` is 1, `txq_pop` stays low.
- R7: Status bit 0 (receive) equals the inverse of `rxq_empty`. An acknowledge write to bit 0 has no effect.
- R8: Status bit 5 (physical-layer summary) is high when any of these holds: `link_chg` and `link_irq_en` are both high; `cnt_rollover` is high; or `tx_fatal` is high and `tx_enable` is low.
- R9: `irq` is high exactly when any bit of the status word ANDed with the mask is 1. The mask is written at address 1, with `bus_wr` high and `bus_addr`=1, and takes effect on the next cycle.
- R10: `bus_rdata` returns the status word at address 0 and the mask at address 1. Status bits 7:6 always read 0.
- R11: After reset the mask and all stored status bits are 0, so `irq` is low and `alloc_failed` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 1 | 0 status/acknowledge, 1 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| rx_abort_nomem | input | 1 | Receive aborted: allocation failed (pulse) |
| rx_abort_long | input | 1 | Receive aborted: frame too long (pulse) |
| rx_abort_discard | input | 1 | Receive aborted: discard control set (pulse) |
| alloc_start | input | 1 | Allocator begins a new request (pulse) |
| alloc_ok | input | 1 | Allocation succeeded (pulse) |
| alloc_fail | input | 1 | Allocation failed (pulse) |
| tx_fifo_empty | input | 1 | Transmit queue empty level |
| txq_empty | input | 1 | Transmit-completion queue empty flag |
| rxq_empty | input | 1 | Receive packet-number queue empty flag |
| link_chg | input | 1 | Link status change pending |
| link_irq_en | input | 1 | Link change interrupt enable |
| cnt_rollover | input | 1 | Statistics counter rollover pending |
| tx_fatal | input | 1 | Fatal transmit error pending |
| tx_enable | input | 1 | Transmitter enable |
| status | output | 8 | Status word |
| irq | output | 1 | Masked interrupt request |
| alloc_failed | output | 1 | Allocation result failed flag |
| txq_pop | output | 1 | Pop strobe for the transmit-completion queue |

## Verification
The bench targets three races: an abort pulse that coincides with an overrun acknowledge, an acknowledge of transmit-empty while the FIFO is still empty, and an allocation success that coincides with a new request. A design that lets the acknowledge or the clear win would drop an event that software has not yet seen. The bench also acknowledges the live and allocator-owned positions. A design that stores those bits would let the acknowledge wrongly clear them, and a design that pops an empty completion queue would corrupt it. Finally, the bench walks every physical-layer cause with its enable both on and off, and checks masked and unmasked interrupt cases.

// File: rtl/eth_irq_status.sv
module eth_irq_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         rx_abort_nomem,
  input  logic         rx_abort_long,
  input  logic         rx_abort_discard,
  input  logic         alloc_start,
  input  logic         alloc_ok,
  input  logic         alloc_fail,
  input  logic         tx_fifo_empty,
  input  logic         txq_empty,
  input  logic         rxq_empty,
  input  logic         link_chg,
  input  logic         link_irq_en,
  input  logic         cnt_rollover,
  input  logic         tx_fatal,
  input  logic         tx_enable,
  output logic [W-1:0] status,
  output logic         irq,
  output logic         alloc_failed,
  output logic         txq_pop
);

  localparam int B_RX   = 0;
  localparam int B_TXD  = 1;
  localparam int B_TXE  = 2;
  localparam int B_ALOC = 3;
  localparam int B_OVRN = 4;
  localparam int B_PHY  = 5;

  logic [W-1:0] mask_q;
  logic         ovrn_q, txe_q, aloc_q;

  wire ack     = bus_wr && (bus_addr == 1'b0);
  wire mask_we = bus_wr && (bus_addr == 1'b1);
  wire ovrn_ev = rx_abort_nomem | rx_abort_long | rx_abort_discard;
  wire phy_sum = (link_chg & link_irq_en) | cnt_rollover | (tx_fatal & ~tx_enable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      ovrn_q <= 1'b0;
      txe_q  <= 1'b0;
      aloc_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= bus_wdata;
      ovrn_q <= ovrn_ev | (ovrn_q & ~(ack & bus_wdata[B_OVRN]));
      txe_q  <= tx_fifo_empty | (txe_q & ~(ack & bus_wdata[B_TXE]));
      if (alloc_ok)                       aloc_q <= 1'b1;
      else if (alloc_start || alloc_fail) aloc_q <= 1'b0;
    end
  end

  always_comb begin
    status         = '0;
    status[B_RX]   = ~rxq_empty;
    status[B_TXD]  = ~txq_empty;
    status[B_TXE]  = txe_q;
    status[B_ALOC] = aloc_q;
    status[B_OVRN] = ovrn_q;
    status[B_PHY]  = phy_sum;
  end

  assign irq          = |(status & mask_q);
  assign alloc_failed = ~aloc_q;
  assign txq_pop      = ack & bus_wdata[B_TXD] & ~txq_empty;
  assign bus_rdata    = bus_addr ? mask_q : status;

  assert_ovrn_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ovrn_ev |=> status[B_OVRN]);

  assert_ovrn_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status[B_OVRN] && !(ack && bus_wdata[B_OVRN])) |=> status[B_OVRN]);

  assert_alloc_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> (status[B_ALOC] && !alloc_failed));

  assert_alloc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((alloc_start || alloc_fail) && !alloc_ok) |=> !status[B_ALOC]);

  assert_txe_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_empty |=> status[B_TXE]);

  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> (!txq_empty && bus_wr));

  assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (bus_addr == 1'b0 || bus_rdata == $past(bus_wdata)));

endmodule

// File: tb/eth_irq_status_tb.sv
module eth_irq_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, status;
  logic rx_abort_nomem = 0, rx_abort_long = 0, rx_abort_discard = 0;
  logic alloc_start = 0, alloc_ok = 0, alloc_fail = 0;
  logic tx_fifo_empty = 0, txq_empty = 1, rxq_empty = 1;
  logic link_chg = 0, link_irq_en = 0, cnt_rollover = 0, tx_fatal = 0, tx_enable = 1;
  logic irq, alloc_failed, txq_pop;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  eth_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_abort_nomem(rx_abort_nomem), .rx_abort_long(rx_abort_long),
    .rx_abort_discard(rx_abort_discard), .alloc_start(alloc_start),
    .alloc_ok(alloc_ok), .alloc_fail(alloc_fail), .tx_fifo_empty(tx_fifo_empty),
    .txq_empty(txq_empty), .rxq_empty(rxq_empty), .link_chg(link_chg),
    .link_irq_en(link_irq_en), .cnt_rollover(cnt_rollover), .tx_fatal(tx_fatal),
    .tx_enable(tx_enable), .status(status), .irq(irq),
    .alloc_failed(alloc_failed), .txq_pop(txq_pop)
  );

  // {link_chg, link_irq_en, cnt_rollover, tx_fatal, tx_enable, expected bit 5}
  localparam logic [5:0] PHY_VEC [10] = '{
    6'b00000_0, 6'b10000_0, 6'b01000_0, 6'b11000_1, 6'b00100_1,
    6'b00011_0, 6'b00010_1, 6'b00001_0, 6'b10011_0, 6'b11111_1
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ack_write(input logic [7:0] d);
    bus_wr = 1; bus_addr = 0; bus_wdata = d;
    step();
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic mask_write(input logic [7:0] d);
    bus_wr = 1; bus_addr = 1; bus_wdata = d;
    step();
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step();
    // R11 reset state
    chk("R11 status", status, 8'h00);
    chk("R11 irq", {7'b0, irq}, 8'h00);
    chk("R11 alloc_failed", {7'b0, alloc_failed}, 8'h01);
    rst_n = 1;
    step();
    bus_addr = 1; #1;
    chk("R11 mask", bus_rdata, 8'h00);
    bus_addr = 0;

    // R8 vector table
    foreach (PHY_VEC[i]) begin
      {link_chg, link_irq_en, cnt_rollover, tx_fatal, tx_enable} = PHY_VEC[i][5:1];
      #1;
      chk("R8 phy summary", {7'b0, status[5]}, {7'b0, PHY_VEC[i][0]});
    end
    {link_chg, link_irq_en, cnt_rollover, tx_fatal, tx_enable} = 5'b00001;
    step();

    // R1 / R2 overrun, each cause
    rx_abort_nomem = 1; step(); rx_abort_nomem = 0;
    chk("R1 ovrn nomem", {7'b0, status[4]}, 8'h01);
    ack_write(8'hEF);
    chk("R2 ovrn kept by other ack", {7'b0, status[4]}, 8'h01);
    ack_write(8'h10);
    chk("R2 ovrn cleared", {7'b0, status[4]}, 8'h00);
    rx_abort_long = 1; step(); rx_abort_long = 0;
    chk("R1 ovrn long", {7'b0, status[4]}, 8'h01);
    ack_write(8'h10);
    rx_abort_discard = 1; step(); rx_abort_discard = 0;
    chk("R1 ovrn discard", {7'b0, status[4]}, 8'h01);
    ack_write(8'h10);
    rx_abort_long = 1;
    ack_write(8'h10);
    rx_abort_long = 0;
    chk("R2 event wins over ack", {7'b0, status[4]}, 8'h01);

    // R9 / R10 mask and irq
    mask_write(8'h10);
    bus_addr = 1; #1;
    chk("R10 mask readback", bus_rdata, 8'h10);
    bus_addr = 0; #1;
    chk("R10 status readback", bus_rdata, 8'h10);
    chk("R9 irq masked on", {7'b0, irq}, 8'h01);
    mask_write(8'hC1);
    chk("R9 irq masked off", {7'b0, irq}, 8'h00);
    ack_write(8'h10);
    chk("R10 upper bits zero", {6'b0, status[7:6]}, 8'h00);

    // R3 / R4 allocation
    alloc_ok = 1; step(); alloc_ok = 0;
    chk("R3 alloc set", {7'b0, status[3]}, 8'h01);
    chk("R3 failed flag", {7'b0, alloc_failed}, 8'h00);
    ack_write(8'h08);
    chk("R4 alloc ack ignored", {7'b0, status[3]}, 8'h01);
    alloc_start = 1; step(); alloc_start = 0;
    chk("R4 clear on start", {7'b0, status[3]}, 8'h00);
    chk("R3 failed flag high", {7'b0, alloc_failed}, 8'h01);
    alloc_ok = 1; step(); alloc_ok = 0;
    alloc_fail = 1; step(); alloc_fail = 0;
    chk("R4 clear on fail", {7'b0, status[3]}, 8'h00);
    alloc_ok = 1; alloc_start = 1; step(); alloc_ok = 0; alloc_start = 0;
    chk("R4 ok wins", {7'b0, status[3]}, 8'h01);

    // R5 transmit empty
    tx_fifo_empty = 1; step(); tx_fifo_empty = 0;
    chk("R5 txe set", {7'b0, status[2]}, 8'h01);
    step();
    chk("R5 txe held", {7'b0, status[2]}, 8'h01);
    ack_write(8'h04);
    chk("R5 txe cleared", {7'b0, status[2]}, 8'h00);
    tx_fifo_empty = 1; step();
    ack_write(8'h04);
    chk("R5 txe relatches while empty", {7'b0, status[2]}, 8'h01);
    tx_fifo_empty = 0; ack_write(8'h04);

    // R6 transmit done and pop
    txq_empty = 0; #1;
    chk("R6 txd live", {7'b0, status[1]}, 8'h01);
    bus_wr = 1; bus_addr = 0; bus_wdata = 8'h02; #1;
    chk("R6 pop on ack", {7'b0, txq_pop}, 8'h01);
    step(); bus_wr = 0; bus_wdata = 0; #1;
    chk("R6 no pop idle", {7'b0, txq_pop}, 8'h00);
    txq_empty = 1; #1;
    chk("R6 txd drops", {7'b0, status[1]}, 8'h00);
    bus_wr = 1; bus_wdata = 8'h02; #1;
    chk("R6 no pop when empty", {7'b0, txq_pop}, 8'h00);
    step(); bus_wr = 0; bus_wdata = 0;

    // R7 receive
    rxq_empty = 0; #1;
    chk("R7 rx live", {7'b0, status[0]}, 8'h01);
    mask_write(8'h01);
    chk("R9 irq from rx", {7'b0, irq}, 8'h01);
    ack_write(8'h01);
    chk("R7 ack ignored", {7'b0, status[0]}, 8'h01);
    rxq_empty = 1; #1;
    chk("R7 rx drops", {7'b0, irq}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule